// File: doc/BRIEF.md
# Private Timer Interrupt Edge Router

This block sits between the per-core private timers and watchdogs of a small multi-core cluster and the per-core private-interrupt pending logic of an interrupt controller. Each core owns two level-sensitive interrupt lines: a timer line and a watchdog line. The block remembers the last sampled level of every line and turns each low-to-high transition into a single-cycle set-pending pulse. The position of the pulse tells the controller which core it targets and which private interrupt ID to set.

The lines arrive as one packed vector with two lines per core. The target core is the line index shifted right by one. The interrupt ID is 29 plus the low bit of the index. The output vector uses the same indexing, so bit `2c+k` means "set ID 29+k pending for core c". Storage is sized for `MAX_CORES` cores. `ACTIVE_CORES` selects how many of them are populated; lines belonging to unpopulated cores are discarded before they reach the edge detector. Inputs are assumed to be synchronous to `clk`.

Top module: `prv_tick_edge_router`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `pend_set` and the stored previous level of every line to 0.
- R2: Bit `2c+k` of `pend_set` belongs to input bit `2c+k`. It targets core `c`. With k=0 the line is a timer and the ID is 29; with k=1 it is a watchdog and the ID is 30.
- R3: A line sampled low at one rising edge and high at the next makes its `pend_set` bit high for the cycle that follows that second edge.
- R4: A pulse lasts exactly one clock cycle, even if the line stays high for many cycles.
- R5: A line that stays low, stays high, or falls produces no pulse.
- R6: When several live lines rise at the same edge, all of their `pend_set` bits are high in the same cycle. No request is merged or dropped.
- R7: Lines with index at or above `2*ACTIVE_CORES` never produce a pulse, whatever their levels.
- R8: A live line that is high while reset is released counts as a rising edge at the first edge after reset, because its stored previous level was cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_in | input | 2*MAX_CORES | Level interrupt lines; bit 2c is the timer of core c, bit 2c+1 is its watchdog |
| pend_set | output | 2*MAX_CORES | One-cycle set-pending pulses, same indexing as `lvl_in` |

## Verification
The hardest case to reach from the ports is a line that is already high when reset releases (R8). Here an edge has to be inferred from cleared storage and not from a real transition. The bench holds a mix of lines high through reset and checks which of them pulse right after reset, including lines of an unpopulated core. Simultaneous rises on every line, held levels and falls are driven in directed steps. A long stretch of random levels follows, compared each cycle against a behavioural model that keeps its own previous-level array.

// File: rtl/prv_tick_edge_router.sv
module prv_tick_edge_router #(
  parameter int MAX_CORES    = 4,
  parameter int ACTIVE_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*MAX_CORES-1:0] lvl_in,
  output logic [2*MAX_CORES-1:0] pend_set
);
  localparam int NLINES = 2 * MAX_CORES;
  localparam int NLIVE  = 2 * ACTIVE_CORES;
  localparam logic [NLINES-1:0] LIVE_MASK = {NLINES{1'b1}} >> (NLINES - NLIVE);

  logic [NLINES-1:0] live;
  logic [NLINES-1:0] prev_q;

  assign live = lvl_in & LIVE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      pend_set <= '0;
    end else begin
      prev_q   <= live;
      pend_set <= live & ~prev_q;
    end
  end
endmodule

// File: rtl/prv_tick_edge_router_chk.sv
module prv_tick_edge_router_chk #(
  parameter int MAX_CORES    = 4,
  parameter int ACTIVE_CORES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*MAX_CORES-1:0] lvl_in,
  input logic [2*MAX_CORES-1:0] pend_set
);
  localparam int NLINES = 2 * MAX_CORES;
  localparam int NLIVE  = 2 * ACTIVE_CORES;

  logic clocked_q = 1'b0;
  always_ff @(posedge clk) clocked_q <= 1'b1;

  initial p_cfg_r7: assert (ACTIVE_CORES <= MAX_CORES && ACTIVE_CORES > 0);

  always @(negedge clk)
    if (clocked_q && !rst_n)
      p_reset_clear_r1: assert (pend_set == '0);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set[i] |=> !pend_set[i]);
    p_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set[i] |-> $past(lvl_in[i]));
    if (i < NLIVE) begin : g_live
      p_rise_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_in[i]) |=> pend_set[i]);
    end else begin : g_dead
      p_dead_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_set[i]);
    end
  end
endmodule

bind prv_tick_edge_router prv_tick_edge_router_chk #(
  .MAX_CORES(MAX_CORES), .ACTIVE_CORES(ACTIVE_CORES)
) u_chk (.*);

// File: tb/sim_prv_tick_edge_router.sv
`timescale 1ns/1ps
module sim_prv_tick_edge_router;
  localparam int MAXC = 4;
  localparam int ACTC = 3;
  localparam int NL   = 2 * MAXC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lvl_in = '0;
  logic [NL-1:0] pend_set;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mprev [NL];
  logic [NL-1:0] exp_q = '0;

  always #2 clk = ~clk;

  prv_tick_edge_router #(.MAX_CORES(MAXC), .ACTIVE_CORES(ACTC)) u0 (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .pend_set(pend_set));

  // behavioural reference: previous level per line, edge gives a request
  always @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      int lv;
      lv = (i < 2*ACTC && lvl_in[i]) ? 1 : 0;
      if (!rst_n) begin
        mprev[i] = 0;
        exp_q[i] = 1'b0;
      end else begin
        exp_q[i] = (lv == 1 && mprev[i] == 0);
        mprev[i] = lv;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pend_set !== exp_q) begin
        errors++;
        $display("FAIL R2 R3 R5 model compare: actual %b expected %b", pend_set, exp_q);
      end
    end
  end

  task automatic chk(input string tag, input logic [NL-1:0] expv);
    checks++;
    if (pend_set !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, pend_set, expv);
    end
  endtask

  task automatic step(input logic [NL-1:0] v);
    @(negedge clk);
    lvl_in = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    lvl_in = 8'b1100_0101;
    repeat (3) @(negedge clk);
    chk("R1 reset state", '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 high through reset", 8'b0000_0101);
    step(8'b1100_0101);
    chk("R4 held high no repeat", '0);
    step(8'b0000_0000);
    chk("R5 fall no pulse", '0);
    step(8'b0000_0010);
    chk("R2 core0 watchdog id30 bit1", 8'b0000_0010);
    step(8'b0000_0010);
    chk("R4 pulse one cycle", '0);
    step(8'b0001_0010);
    chk("R2 core2 timer id29 bit4", 8'b0001_0000);
    step(8'b0000_0000);
    chk("R5 fall quiet", '0);
    step(8'b1111_1111);
    chk("R6 all live lines together", 8'b0011_1111);
    step(8'b1111_1111);
    chk("R4 held all", '0);
    step(8'b0000_0000);
    step(8'b1100_0000);
    chk("R7 dead core lines", '0);
    step(8'b0000_1000);
    chk("R3 core1 watchdog rise", 8'b0000_1000);
    step(8'b1010_0100);
    chk("R6 mixed rise and fall", 8'b0010_0100);
    for (int n = 0; n < 400; n++) step(NL'($urandom));
    step('0);
    @(negedge clk);
    lvl_in = 8'b1111_1111;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 reset mid run", '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 rise after second reset", 8'b0011_1111);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    done = 1'b1;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule